// File: doc/BRIEF.md
# GPIO Bus Access Checker

A passive monitor placed on the memory-mapped bus port of a 32-bit general purpose I/O peripheral. The peripheral ignores byte enables and latches the whole data word on every store, so any store narrower than a word or aimed at a non-aligned byte address leaves unknown values in its registers. Its edge-capture register is write-1-to-clear: a written zero leaves its bit alone, so a store of an all-zero word there clears nothing. Software that tries to clear that register by writing zero is making a common mistake.

The checker samples the bus in every cycle where the clock enable is high. It reports each of the two problems with a one-cycle warning pulse, a sticky flag and a saturating violation counter. Each check has its own enable. Loads of any width are never reported. The checker drives nothing onto the bus.

Top module: `gpio_access_checker`

## Requirements
- R1: A store (sel=1, wr_n=0) in a sampled cycle whose byte enables are not all ones (4'b1111) sets narrow_warn high for exactly the following clock cycle.
- R2: A store in a sampled cycle whose low byte address bits byte_lo are nonzero sets narrow_warn high in the following cycle, even when all byte enables are set.
- R3: A load (sel=1, wr_n=1) or an idle bus cycle (sel=0) never raises either warning, whatever the byte enables, address and data are.
- R4: A store to word address 3 with an all-zero data word sets clear_warn high in the following cycle. A nonzero word stored at address 3, or a zero word stored at any other address, raises no clear_warn.
- R5: When narrow_en (or clear_en) is low, the matching check raises no pulse, does not set its flag and does not change its counter.
- R6: In a cycle where clk_en is low the bus is not sampled, and the following cycle carries no warning.
- R7: A flag goes high together with its warning pulse and stays high until flag_clr is high at a clock edge. If flag_clr and a new violation arrive in the same cycle, the flag stays set.
- R8: Each check has a 16-bit counter that adds one for each reported violation, stops at 65535 and is zero after reset.
- R9: A store that breaks both rules, such as a byte-wide store of zero to address 3, raises both warnings in the same cycle.
- R10: After the asynchronous active-low reset, all warnings, flags and counters are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Sample enable for the bus |
| sel | input | 1 | Chip select of the peripheral |
| wr_n | input | 1 | Write strobe, active low |
| word_addr | input | 4 | Word address of the access |
| byte_lo | input | 2 | Low byte address bits |
| byte_en | input | 4 | Byte enables |
| wdata | input | 32 | Write data |
| narrow_en | input | 1 | Enables the narrow or misaligned store check |
| clear_en | input | 1 | Enables the ineffective-clear check |
| flag_clr | input | 1 | Clears both sticky flags |
| narrow_warn | output | 1 | One-cycle narrow or misaligned store warning |
| clear_warn | output | 1 | One-cycle ineffective-clear warning |
| narrow_flag | output | 1 | Sticky narrow store flag |
| clear_flag | output | 1 | Sticky ineffective-clear flag |
| narrow_cnt | output | 16 | Saturating count of narrow stores |
| clear_cnt | output | 16 | Saturating count of ineffective clears |

## Verification
The bench drives full aligned stores, partial byte-enable stores with each byte enable pattern, misaligned stores with full enables, and loads with partial enables. This separates a check that decodes the byte enables from one that decodes the address bits, and shows whether the direction of the access is used at all. Zero and nonzero words are stored to address 3 and to its neighbours, which tells an exact address and data match from a partial one. Runs with each check disabled, with clk_en low, with clear and violation in the same cycle, and a run of more than 65535 violations test gating, flag priority and saturation.

// File: rtl/gpio_access_checker.sv
module gpio_access_checker #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 16,
  parameter int EDGE_OFS = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clk_en,
  input  logic                       sel,
  input  logic                       wr_n,
  input  logic [ADDR_W-1:0]          word_addr,
  input  logic [$clog2(DATA_W/8)-1:0] byte_lo,
  input  logic [DATA_W/8-1:0]        byte_en,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       narrow_en,
  input  logic                       clear_en,
  input  logic                       flag_clr,
  output logic                       narrow_warn,
  output logic                       clear_warn,
  output logic                       narrow_flag,
  output logic                       clear_flag,
  output logic [CNT_W-1:0]           narrow_cnt,
  output logic [CNT_W-1:0]           clear_cnt
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [ADDR_W-1:0] EDGE_ADDR = ADDR_W'(EDGE_OFS);

  logic store, narrow_v, clear_v;

  assign store    = clk_en && sel && !wr_n;
  assign narrow_v = store && narrow_en && (byte_en != {BE_W{1'b1}} || byte_lo != '0);
  assign clear_v  = store && clear_en && word_addr == EDGE_ADDR && wdata == '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_warn <= 1'b0;
      clear_warn  <= 1'b0;
    end else begin
      narrow_warn <= narrow_v;
      clear_warn  <= clear_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_flag <= 1'b0;
      clear_flag  <= 1'b0;
    end else begin
      if (narrow_v)      narrow_flag <= 1'b1;
      else if (flag_clr) narrow_flag <= 1'b0;
      if (clear_v)       clear_flag  <= 1'b1;
      else if (flag_clr) clear_flag  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      narrow_cnt <= '0;
      clear_cnt  <= '0;
    end else begin
      if (narrow_v && narrow_cnt != CNT_MAX) narrow_cnt <= narrow_cnt + 1'b1;
      if (clear_v && clear_cnt != CNT_MAX)   clear_cnt  <= clear_cnt + 1'b1;
    end
  end

  // R3
  load_never_warns_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_warn || clear_warn) |-> $past(sel && !wr_n && clk_en));

  // R5
  disabled_check_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!narrow_en |=> !narrow_warn) and (!clear_en |=> !clear_warn));

  // R7
  warn_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_warn |-> narrow_flag) and (clear_warn |-> clear_flag));

  // R7
  flag_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !narrow_v) |=> !narrow_flag);

  // R8
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_warn && $past(narrow_cnt) != CNT_MAX) |-> narrow_cnt == $past(narrow_cnt) + 1'b1);

  // R8
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_warn |-> $stable(clear_cnt));
endmodule

// File: tb/sim_gpio_access_checker.sv
module sim_gpio_access_checker;
  logic clk = 0, rst_n = 0, clk_en = 1, sel = 0, wr_n = 1;
  logic [3:0] word_addr = 0, byte_en = 4'hF;
  logic [1:0] byte_lo = 0;
  logic [31:0] wdata = 0;
  logic narrow_en = 1, clear_en = 1, flag_clr = 0;
  logic narrow_warn, clear_warn, narrow_flag, clear_flag;
  logic [15:0] narrow_cnt, clear_cnt;

  int vectors = 0, miscompares = 0;
  int m_nw = 0, m_cw = 0, m_nf = 0, m_cf = 0, m_nc = 0, m_cc = 0;
  string ph = "R10";

  always #2 clk = ~clk;

  gpio_access_checker u0 (.*);

  task automatic cmp(string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", ph, what, act, exp);
    end
  endtask

  task automatic compare_all();
    cmp("narrow_warn", narrow_warn, m_nw);
    cmp("clear_warn", clear_warn, m_cw);
    cmp("narrow_flag", narrow_flag, m_nf);
    cmp("clear_flag", clear_flag, m_cf);
    cmp("narrow_cnt", narrow_cnt, m_nc);
    cmp("clear_cnt", clear_cnt, m_cc);
  endtask

  task automatic step(logic s, logic w, logic [3:0] a, logic [1:0] lo, logic [3:0] be,
                      logic [31:0] d);
    bit st, nv, cv;
    sel = s; wr_n = w; word_addr = a; byte_lo = lo; byte_en = be; wdata = d;
    @(posedge clk);
    st = clk_en && s && !w;
    nv = st && narrow_en && (be != 4'hF || lo != 0);
    cv = st && clear_en && a == 3 && d == 0;
    m_nw = nv; m_cw = cv;
    m_nf = nv ? 1 : (flag_clr ? 0 : m_nf);
    m_cf = cv ? 1 : (flag_clr ? 0 : m_cf);
    if (nv && m_nc < 65535) m_nc++;
    if (cv && m_cc < 65535) m_cc++;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #50000000;
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #9;
    compare_all();              // R10 reset state
    rst_n = 1;
    @(negedge clk);
    ph = "R1";
    step(1, 0, 1, 0, 4'hF, 32'h1234);
    for (int i = 0; i < 15; i++) step(1, 0, 1, 0, 4'(i), 32'h55);
    step(0, 1, 0, 0, 4'hF, 0);
    ph = "R2";
    for (int i = 1; i < 4; i++) step(1, 0, 2, 2'(i), 4'hF, 32'hFF);
    ph = "R3";
    for (int i = 0; i < 16; i++) step(1, 1, 3, 2'(i), 4'(i), 0);
    step(0, 0, 3, 1, 4'h1, 0);
    ph = "R4";
    step(1, 0, 3, 0, 4'hF, 0);
    step(1, 0, 3, 0, 4'hF, 32'h8000_0000);
    step(1, 0, 3, 0, 4'hF, 32'h1);
    step(1, 0, 2, 0, 4'hF, 0);
    step(1, 0, 7, 0, 4'hF, 0);
    step(1, 0, 11, 0, 4'hF, 0);
    ph = "R7";
    flag_clr = 1; step(0, 1, 0, 0, 4'hF, 0);
    step(1, 0, 1, 0, 4'h3, 1);
    step(1, 0, 3, 0, 4'hF, 0);
    flag_clr = 0; step(0, 1, 0, 0, 4'hF, 0);
    step(0, 1, 0, 0, 4'hF, 0);
    ph = "R5";
    narrow_en = 0; step(1, 0, 1, 1, 4'h1, 1);
    clear_en = 0;  step(1, 0, 3, 0, 4'hF, 0);
    flag_clr = 1;  step(1, 0, 3, 2, 4'h2, 0);
    flag_clr = 0;  step(0, 1, 0, 0, 4'hF, 0);
    narrow_en = 1; clear_en = 1;
    ph = "R6";
    clk_en = 0;
    step(1, 0, 3, 1, 4'h1, 0);
    step(1, 0, 3, 0, 4'hF, 0);
    clk_en = 1;
    step(0, 1, 0, 0, 4'hF, 0);
    ph = "R9";
    step(1, 0, 3, 0, 4'h1, 0);
    step(1, 0, 3, 3, 4'hF, 0);
    ph = "R8";
    for (int i = 0; i < 65540; i++) step(1, 0, 3, 1, 4'h4, 0);
    step(0, 1, 0, 0, 4'hF, 0);
    ph = "R10";
    rst_n = 0; m_nw = 0; m_cw = 0; m_nf = 0; m_cf = 0; m_nc = 0; m_cc = 0;
    #1;
    compare_all();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule